// File: doc/BRIEF.md
# Control and Status Register Read-Modify-Write Unit

This unit holds a small bank of 64-bit scratch control/status registers and carries out the three atomic access kinds a core issues against them: replace, set selected bits and clear selected bits. Each kind comes in two flavours. One takes its operand from a general register. The other takes a 5-bit immediate that is zero-extended to 64 bits. Every access hands back the value the register held before the access, ready for the destination register. A request is presented for one cycle with `req_valid`, and the response appears on the following cycle.

The same request port also carries the system encodings that share the function code 0. Three 12-bit codes under that function code raise one-cycle exception strobes: a system call, a breakpoint, and an unimplemented return. Any other code under function code 0, the reserved function code 4, and any register address outside the implemented window all raise the illegal flag and leave every register untouched.

The response path is a small state machine with these states: `ST_IDLE` (no response), `ST_ACK` (register access completed), `ST_SYSCALL`, `ST_BREAK`, `ST_UNIMPL` and `ST_REJECT` (illegal). On each clock edge where `req_valid` is high, the machine moves from whatever state it is in to the state that matches the decoded request. On each edge where `req_valid` is low, it returns to `ST_IDLE`. All response outputs are decoded from the state register.

Top module: `csr_rmw_unit`

## Requirements
- R1: After reset every scratch register reads as zero, and `rsp_done`, `rsp_rdata` and all flags are low.
- R2: `rsp_done` is high in exactly the cycle after each cycle in which `req_valid` is high, and is low otherwise. While `rsp_done` is low, `rsp_rdata` is zero.
- R3: A register access (function codes 1, 2, 3, 5, 6, 7 to a mapped address) returns the register's prior value on `rsp_rdata` with `rsp_done`, and with all flags low.
- R4: Function codes 1 (register operand) and 5 (immediate operand) write the operand into the register unconditionally, zero included.
- R5: Function codes 2 and 6 write old OR operand. Function codes 3 and 7 write old AND NOT operand.
- R6: A set or clear whose operand is zero performs no write, so the register keeps its value.
- R7: For function codes 5, 6 and 7 the operand is `req_zimm` zero-extended to 64 bits, and `req_rs1` is ignored.
- R8: A register access whose address lies outside `CSR_BASE` to `CSR_BASE+NUM_CSR-1` (default 0x7C0 to 0x7C3) raises `rsp_illegal`, returns zero data and changes no register.
- R9: Function code 4 raises `rsp_illegal` for any address and changes no register.
- R10: Under function code 0, address field 0x000 raises `rsp_ecall`, 0x001 raises `rsp_ebreak`, and 0x100 raises `rsp_unimpl`. Any other value raises `rsp_illegal`. None of these changes a register, and at most one flag is high at a time.
- R11: Each scratch register is independent. A write to one never alters another.
- R12: Requests on consecutive cycles each complete one cycle later, with no bubble, and each sees the effect of the request before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_funct3 | input | 3 | Function code selecting the operation |
| req_addr | input | 12 | Register address, or system code when the function code is 0 |
| req_rs1 | input | 64 | Register operand |
| req_zimm | input | 5 | Immediate operand |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Prior register value, zero for non-access responses |
| rsp_illegal | output | 1 | Illegal request |
| rsp_ecall | output | 1 | System-call exception |
| rsp_ebreak | output | 1 | Breakpoint exception |
| rsp_unimpl | output | 1 | Unimplemented-return exception |

## Verification
The bench sweeps all eight function codes against addresses on each side of the mapped window, every mapped address, and the three system codes. This separates the access path from the reject and exception paths. Register operands of zero, all ones, and shifted or mixed patterns tell replace apart from OR and AND-NOT, and show whether a zero mask suppresses the write. Immediates of 0, 1, 31 and 21 are paired with all-ones register operands, which exposes any leak of `req_rs1` or missing zero extension. The requests run back-to-back against a running model of the register bank, so any cross-register corruption or stale read shows up on a later returned value.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

    typedef enum logic [1:0] {
        OP_WRITE,
        OP_SET,
        OP_CLEAR
    } csr_op_e;

    typedef enum logic [2:0] {
        K_ACCESS,
        K_SYSCALL,
        K_BREAK,
        K_UNIMPL,
        K_REJECT
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_SYSCALL,
        ST_BREAK,
        ST_UNIMPL,
        ST_REJECT
    } rsp_state_e;

    localparam logic [2:0]  F3_SYSTEM   = 3'd0;
    localparam logic [2:0]  F3_RESERVED = 3'd4;
    localparam logic [11:0] SYS_CALL    = 12'h000;
    localparam logic [11:0] SYS_BREAK   = 12'h001;
    localparam logic [11:0] SYS_RET     = 12'h100;

endpackage

// File: rtl/csr_rmw_decode.sv
module csr_rmw_decode
    import csr_rmw_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] CSR_BASE = 12'h7C0,
    parameter int          NUM_CSR  = 4,
    parameter int          IDX_W    = 2
) (
    input  logic [2:0]        funct3,
    input  logic [ADDR_W-1:0] addr,
    output req_kind_e         kind,
    output csr_op_e           op,
    output logic              use_imm,
    output logic [IDX_W-1:0]  idx
);

    logic [ADDR_W-1:0] offset;
    logic              in_window;

    always_comb begin
        offset    = addr - CSR_BASE;
        in_window = (offset < ADDR_W'(NUM_CSR));
        idx       = offset[IDX_W-1:0];
    end

    always_comb begin
        kind    = K_REJECT;
        op      = OP_WRITE;
        use_imm = funct3[2];
        unique case (funct3)
            F3_SYSTEM: begin
                unique case (addr)
                    SYS_CALL:  kind = K_SYSCALL;
                    SYS_BREAK: kind = K_BREAK;
                    SYS_RET:   kind = K_UNIMPL;
                    default:   kind = K_REJECT;
                endcase
            end
            F3_RESERVED: kind = K_REJECT;
            default: begin
                kind = in_window ? K_ACCESS : K_REJECT;
                unique case (funct3[1:0])
                    2'd2:    op = OP_SET;
                    2'd3:    op = OP_CLEAR;
                    default: op = OP_WRITE;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/csr_rmw_alu.sv
module csr_rmw_alu
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  csr_op_e          op,
    input  logic [XLEN-1:0]  old_val,
    input  logic [XLEN-1:0]  operand,
    output logic [XLEN-1:0]  new_val,
    output logic             wr_en
);

    logic mask_zero;

    always_comb begin
        mask_zero = (operand == '0);
        unique case (op)
            OP_SET: begin
                new_val = old_val | operand;
                wr_en   = !mask_zero;
            end
            OP_CLEAR: begin
                new_val = old_val & ~operand;
                wr_en   = !mask_zero;
            end
            default: begin
                new_val = operand;
                wr_en   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/csr_rmw_bank.sv
module csr_rmw_bank #(
    parameter int XLEN    = 64,
    parameter int NUM_CSR = 4,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  rdata
);

    logic [XLEN-1:0] regs [NUM_CSR];

    for (genvar g = 0; g < NUM_CSR; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CSR; i++) begin
            if (idx == IDX_W'(i)) rdata = regs[i];
        end
    end

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int          XLEN     = 64,
    parameter int          ZIMM_W   = 5,
    parameter logic [11:0] CSR_BASE = 12'h7C0,
    parameter int          NUM_CSR  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_funct3,
    input  logic [11:0]       req_addr,
    input  logic [XLEN-1:0]   req_rs1,
    input  logic [ZIMM_W-1:0] req_zimm,
    output logic              rsp_done,
    output logic [XLEN-1:0]   rsp_rdata,
    output logic              rsp_illegal,
    output logic              rsp_ecall,
    output logic              rsp_ebreak,
    output logic              rsp_unimpl
);

    localparam int IDX_W = (NUM_CSR > 1) ? $clog2(NUM_CSR) : 1;

    req_kind_e        kind;
    csr_op_e          op;
    logic             use_imm;
    logic [IDX_W-1:0] idx;
    logic [XLEN-1:0]  operand;
    logic [XLEN-1:0]  old_val;
    logic [XLEN-1:0]  new_val;
    logic             alu_wr;
    logic             bank_we;
    logic [XLEN-1:0]  rdata_q;
    rsp_state_e       state_q, state_d;

    csr_rmw_decode #(
        .ADDR_W   (12),
        .CSR_BASE (CSR_BASE),
        .NUM_CSR  (NUM_CSR),
        .IDX_W    (IDX_W)
    ) u_decode (
        .funct3  (req_funct3),
        .addr    (req_addr),
        .kind    (kind),
        .op      (op),
        .use_imm (use_imm),
        .idx     (idx)
    );

    always_comb begin
        operand = use_imm ? {{(XLEN-ZIMM_W){1'b0}}, req_zimm} : req_rs1;
    end

    csr_rmw_alu #(.XLEN(XLEN)) u_alu (
        .op      (op),
        .old_val (old_val),
        .operand (operand),
        .new_val (new_val),
        .wr_en   (alu_wr)
    );

    always_comb begin
        bank_we = req_valid && (kind == K_ACCESS) && alu_wr;
    end

    csr_rmw_bank #(
        .XLEN    (XLEN),
        .NUM_CSR (NUM_CSR),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .idx   (idx),
        .wdata (new_val),
        .rdata (old_val)
    );

    // Next-state selection: each request jumps straight to its response state.
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            unique case (kind)
                K_ACCESS:  state_d = ST_ACK;
                K_SYSCALL: state_d = ST_SYSCALL;
                K_BREAK:   state_d = ST_BREAK;
                K_UNIMPL:  state_d = ST_UNIMPL;
                default:   state_d = ST_REJECT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (req_valid && (kind == K_ACCESS)) ? old_val : '0;
        end
    end

    // Response outputs decoded from the state register.
    always_comb begin
        rsp_done    = 1'b1;
        rsp_illegal = 1'b0;
        rsp_ecall   = 1'b0;
        rsp_ebreak  = 1'b0;
        rsp_unimpl  = 1'b0;
        unique case (state_q)
            ST_IDLE:    rsp_done    = 1'b0;
            ST_ACK:     rsp_done    = 1'b1;
            ST_SYSCALL: rsp_ecall   = 1'b1;
            ST_BREAK:   rsp_ebreak  = 1'b1;
            ST_UNIMPL:  rsp_unimpl  = 1'b1;
            ST_REJECT:  rsp_illegal = 1'b1;
            default:    rsp_done    = 1'b0;
        endcase
        rsp_rdata = rdata_q;
    end

endmodule

// File: rtl/csr_rmw_checker.sv
module csr_rmw_checker #(
    parameter int          XLEN     = 64,
    parameter logic [11:0] CSR_BASE = 12'h7C0,
    parameter int          NUM_CSR  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      req_funct3,
    input logic [11:0]     req_addr,
    input logic            rsp_done,
    input logic [XLEN-1:0] rsp_rdata,
    input logic            rsp_illegal,
    input logic            rsp_ecall,
    input logic            rsp_ebreak,
    input logic            rsp_unimpl
);

    logic [11:0] chk_off;
    logic        chk_mapped;
    logic        chk_access_code;

    always_comb begin
        chk_off         = req_addr - CSR_BASE;
        chk_mapped      = (chk_off < 12'(NUM_CSR));
        chk_access_code = (req_funct3 != 3'd0) && (req_funct3 != 3'd4);
    end

    p_done_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done);

    p_no_done_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_done);

    p_rdata_zero_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> (rsp_rdata == '0));

    p_single_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_illegal, rsp_ecall, rsp_ebreak, rsp_unimpl}));

    p_ecall_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_funct3 == 3'd0 && req_addr == 12'h000) |=> rsp_ecall);

    p_reserved_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_funct3 == 3'd4) |=> (rsp_illegal && rsp_rdata == '0));

    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_access_code && !chk_mapped) |=> (rsp_illegal && rsp_rdata == '0));

    p_access_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_access_code && chk_mapped) |=>
            (rsp_done && !rsp_illegal && !rsp_ecall && !rsp_ebreak && !rsp_unimpl));

endmodule

bind csr_rmw_unit csr_rmw_checker #(
    .XLEN     (XLEN),
    .CSR_BASE (CSR_BASE),
    .NUM_CSR  (NUM_CSR)
) u_csr_rmw_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_funct3  (req_funct3),
    .req_addr    (req_addr),
    .rsp_done    (rsp_done),
    .rsp_rdata   (rsp_rdata),
    .rsp_illegal (rsp_illegal),
    .rsp_ecall   (rsp_ecall),
    .rsp_ebreak  (rsp_ebreak),
    .rsp_unimpl  (rsp_unimpl)
);

// File: tb/tb_csr_rmw_unit.sv
`timescale 1ns/1ps
module tb_csr_rmw_unit;

    localparam int          XLEN = 64;
    localparam logic [11:0] BASE = 12'h7C0;
    localparam int          NCSR = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2:0]      req_funct3 = '0;
    logic [11:0]     req_addr = '0;
    logic [XLEN-1:0] req_rs1 = '0;
    logic [4:0]      req_zimm = '0;
    logic            rsp_done, rsp_illegal, rsp_ecall, rsp_ebreak, rsp_unimpl;
    logic [XLEN-1:0] rsp_rdata;

    int vectors = 0;
    int miscompares = 0;
    logic [XLEN-1:0] model [NCSR];

    always #2 clk = ~clk;

    csr_rmw_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_funct3(req_funct3),
        .req_addr(req_addr), .req_rs1(req_rs1), .req_zimm(req_zimm),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal),
        .rsp_ecall(rsp_ecall), .rsp_ebreak(rsp_ebreak), .rsp_unimpl(rsp_unimpl)
    );

    function automatic bit is_mapped(input logic [11:0] a);
        return (int'(a) >= int'(BASE)) && (int'(a) < int'(BASE) + NCSR);
    endfunction

    function automatic string tag_of(input logic [2:0] f3, input logic [11:0] a,
                                     input logic [XLEN-1:0] opnd);
        if (f3 == 3'd0) return "R10";
        if (f3 == 3'd4) return "R9";
        if (!is_mapped(a)) return "R8";
        if (f3 == 3'd1) return "R3 R4";
        if (f3 == 3'd5) return "R4 R7";
        if (opnd == '0) return "R6";
        return f3[2] ? "R5 R7" : "R3 R5";
    endfunction

    task automatic compare(input string tag, input logic e_done, input logic [XLEN-1:0] e_rd,
                           input logic [3:0] e_flags);
        vectors++;
        if (rsp_done !== e_done || rsp_rdata !== e_rd ||
            {rsp_illegal, rsp_ecall, rsp_ebreak, rsp_unimpl} !== e_flags) begin
            miscompares++;
            $display("FAIL %s: got done=%b rdata=%h flags=%b, expected done=%b rdata=%h flags=%b",
                     tag, rsp_done, rsp_rdata,
                     {rsp_illegal, rsp_ecall, rsp_ebreak, rsp_unimpl}, e_done, e_rd, e_flags);
        end
    endtask

    // Drives one request at a falling edge and checks the response at the next one.
    task automatic apply(input logic [2:0] f3, input logic [11:0] a, input logic [XLEN-1:0] r,
                         input logic [4:0] z, input string tag_in);
        logic [XLEN-1:0] opnd, e_rd;
        logic [3:0]      e_flags;
        string           tag;
        opnd    = f3[2] ? {59'd0, z} : r;
        e_rd    = '0;
        e_flags = 4'b0000;
        tag     = (tag_in == "") ? tag_of(f3, a, opnd) : tag_in;
        if (f3 == 3'd0) begin
            if (a == 12'h000)      e_flags = 4'b0100;
            else if (a == 12'h001) e_flags = 4'b0010;
            else if (a == 12'h100) e_flags = 4'b0001;
            else                   e_flags = 4'b1000;
        end else if (f3 == 3'd4 || !is_mapped(a)) begin
            e_flags = 4'b1000;
        end else begin
            int i;
            i    = int'(a) - int'(BASE);
            e_rd = model[i];
            case (f3[1:0])
                2'd1: model[i] = opnd;
                2'd2: if (opnd != '0) model[i] = model[i] | opnd;
                default: if (opnd != '0) model[i] = model[i] & ~opnd;
            endcase
        end
        req_valid  = 1'b1;
        req_funct3 = f3;
        req_addr   = a;
        req_rs1    = r;
        req_zimm   = z;
        @(negedge clk);
        compare(tag, 1'b1, e_rd, e_flags);
    endtask

    task automatic idle(input string tag);
        req_valid = 1'b0;
        req_rs1   = {XLEN{1'b1}};
        @(negedge clk);
        compare(tag, 1'b0, '0, 4'b0000);
    endtask

    function automatic logic [11:0] addr_pick(input int k);
        case (k)
            0: return 12'h000;
            1: return 12'h001;
            2: return 12'h100;
            3: return BASE - 12'd1;
            8: return BASE + 12'(NCSR);
            9: return 12'hFFF;
            default: return BASE + 12'(k - 4);
        endcase
    endfunction

    initial begin
        for (int i = 0; i < NCSR; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1");
        for (int i = 0; i < NCSR; i++) apply(3'd6, BASE + 12'(i), '1, 5'd0, "R1");
        idle("R2");

        // Distinct values per register, read back: independence and back-to-back.
        for (int i = 0; i < NCSR; i++)
            apply(3'd1, BASE + 12'(i), 64'h1111_0000_0000_0001 * 64'(i + 1), 5'd0, "R11");
        for (int i = 0; i < NCSR; i++) apply(3'd2, BASE + 12'(i), '0, 5'd0, "R11 R12");
        apply(3'd1, BASE, '1, 5'd0, "R12");
        apply(3'd5, BASE, '1, 5'd31, "R7 R12");
        apply(3'd2, BASE, '0, 5'd0, "R7");
        idle("R2");

        // Sweep function code x address x operand patterns.
        for (int f = 0; f < 8; f++) begin
            for (int k = 0; k < 10; k++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int zi = 0; zi < 4; zi++) begin
                        logic [XLEN-1:0] r;
                        logic [4:0]      z;
                        case (p)
                            0: r = '0;
                            1: r = '1;
                            2: r = 64'hA5A5_5A5A_0F0F_F0F0 ^ 64'(vectors);
                            default: r = 64'd1 << (vectors % 64);
                        endcase
                        case (zi)
                            0: z = 5'd0;
                            1: z = 5'd1;
                            2: z = 5'd31;
                            default: z = 5'd21;
                        endcase
                        apply(3'(f), addr_pick(k), r, z, "");
                        if (vectors % 7 == 0) idle("R2");
                    end
                end
            end
        end
        for (int i = 0; i < NCSR; i++) apply(3'd3, BASE + 12'(i), '0, 5'd0, "R11");
        idle("R2");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule